// File: doc/BRIEF.md
# Row-Reduction Multiply-Accumulate Unit

This block multiplies two unsigned 16-bit operands and adds the 32-bit product into a 40-bit running total on every cycle that carries a valid input. It serves filter and correlation datapaths that form sums of products, one product per valid cycle, with no pause between back-to-back operands. The accumulator's eight extra bits above the product width leave room for long runs before the total wraps.

The product is formed in three phases. First, AND gates build one row per bit of `op_h`. Next, the rows are folded into a running sum one row at a time. Each fold uses a 16-bit multi-bit adder, and the folds alternate between a parallel-prefix (Brent-Kung) adder and a grouped carry-lookahead adder. A wide carry-lookahead adder then adds the finished product to the stored total. Both the multiply and the add sit in front of one register, so a sum appears one cycle after its valid input. A synchronous clear empties the total, and it wins over a valid input in the same cycle.

Top module: `mac_row_unit`

## Requirements
- R1: With the total cleared, one valid cycle with operands x and h leaves the total equal to the exact unsigned product x*h. The largest case, 0xFFFF*0xFFFF, gives 0xFFFE0001.
- R2: On a valid cycle without clear, the total seen one clock later is the previous total plus x*h.
- R3: A cycle with `clr` high leaves the total at zero one clock later, whatever `in_vld`, `op_x` and `op_h` are.
- R4: A cycle with `in_vld` low and `clr` low leaves the total unchanged, whatever values `op_x` and `op_h` carry.
- R5: The total is 40 bits wide and wraps modulo 2^40 when a sum exceeds that range.
- R6: When each operand has a single bit set, at positions a and b, the product has exactly one bit set, at position a+b. Any zero operand gives a zero product.
- R7: Valid cycles may follow one another without a gap, and each one adds its own product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear of the total; wins over in_vld |
| in_vld | input | 1 | High when op_x and op_h carry a pair to accumulate |
| op_x | input | 16 | Unsigned multiplier operand |
| op_h | input | 16 | Unsigned multiplicand operand |
| acc_q | output | 40 | Registered running total |

## Verification
Every effect of a cycle's inputs on `acc_q` is due exactly one rising edge later: a clear, an add, or a hold all show after that single edge. The bench therefore drives each input set just after a rising edge and samples `acc_q` one time unit after the following edge. That timing reads the register after it updates and before the next inputs are applied. The bench computes every expected total arithmetically from the operands it applied, and that includes the wrap past 2^40 after a long run of maximum products.

// File: rtl/mac_row_pkg.sv
package mac_row_pkg;

  localparam int unsigned MAXW = 64;

  // One partial-product row: the multiplier operand gated by one multiplicand bit.
  function automatic logic [MAXW-1:0] gate_row(input logic [MAXW-1:0] x, input logic hb);
    return hb ? x : '0;
  endfunction

  // Log2 of a width, for prefix tree depth.
  function automatic int unsigned tree_depth(input int unsigned w);
    int unsigned d;
    d = 0;
    while ((1 << d) < w) d++;
    return d;
  endfunction

  // True when the width is a power of two.
  function automatic bit is_pow2(input int unsigned w);
    return (w != 0) && ((w & (w - 1)) == 0);
  endfunction

endpackage

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int unsigned W   = 40,
  parameter int unsigned GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int unsigned NG = (W + GRP - 1) / GRP;

  logic [W-1:0] gen_b, prop_b;
  assign gen_b  = a & b;
  assign prop_b = a ^ b;

  always_comb begin
    logic [W:0]  cv;
    logic [NG:0] cg;
    logic        gg, pg;
    cv    = '0;
    cg    = '0;
    cg[0] = ci;
    for (int k = 0; k < int'(NG); k++) begin
      gg = 1'b0;
      pg = 1'b1;
      for (int j = k * int'(GRP); (j < (k + 1) * int'(GRP)) && (j < int'(W)); j++) begin
        gg = gen_b[j] | (prop_b[j] & gg);
        pg = pg & prop_b[j];
      end
      cg[k+1] = gg | (pg & cg[k]);
      cv[k*int'(GRP)] = cg[k];
      for (int j = k * int'(GRP); (j < (k + 1) * int'(GRP) - 1) && (j < int'(W) - 1); j++) begin
        cv[j+1] = gen_b[j] | (prop_b[j] & cv[j]);
      end
    end
    s  = prop_b ^ cv[W-1:0];
    co = cg[NG];
  end
endmodule

// File: rtl/bk_adder.sv
module bk_adder
  import mac_row_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int unsigned LV = tree_depth(W);

  logic [W-1:0] g0, p0;
  assign g0 = a & b;
  assign p0 = a ^ b;

  always_comb begin
    logic [W-1:0] gv, pv;
    logic [W:0]   cv;
    gv = g0;
    pv = p0;
    // up-sweep: LV levels
    for (int lv = 1; lv <= int'(LV); lv++) begin
      for (int i = 0; i < int'(W); i++) begin
        if (((i + 1) % (1 << lv)) == 0) begin
          gv[i] = gv[i] | (pv[i] & gv[i - (1 << (lv - 1))]);
          pv[i] = pv[i] & pv[i - (1 << (lv - 1))];
        end
      end
    end
    // down-sweep: LV-1 levels
    for (int lv = int'(LV) - 1; lv >= 1; lv--) begin
      for (int i = 0; i < int'(W); i++) begin
        if ((i >= (1 << lv)) && (((i + 1) % (1 << lv)) == (1 << (lv - 1)))) begin
          gv[i] = gv[i] | (pv[i] & gv[i - (1 << (lv - 1))]);
          pv[i] = pv[i] & pv[i - (1 << (lv - 1))];
        end
      end
    end
    cv    = '0;
    cv[0] = 1'b0;
    for (int i = 0; i < int'(W); i++) cv[i+1] = gv[i];
    s  = p0 ^ cv[W-1:0];
    co = cv[W];
  end
endmodule

// File: rtl/row_mult.sv
module row_mult
  import mac_row_pkg::*;
#(
  parameter int unsigned OPW = 16
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  output logic [2*OPW-1:0] p
);
  localparam bit USE_BK = is_pow2(OPW);

  logic [OPW-1:0] rows [OPW];
  logic [OPW:0]   part [OPW];
  logic [OPW-1:0] low_bits;

  genvar i;
  generate
    for (i = 0; i < int'(OPW); i++) begin : g_row
      logic [MAXW-1:0] gated;
      assign gated   = gate_row(MAXW'(a), b[i]);
      assign rows[i] = gated[OPW-1:0];
    end

    assign part[0] = {1'b0, rows[0]};

    for (i = 1; i < int'(OPW); i++) begin : g_fold
      logic [OPW-1:0] fs;
      logic           fc;
      if (USE_BK && (i % 2 == 1)) begin : g_bk
        bk_adder #(.W(OPW)) u_add (
          .a (part[i-1][OPW:1]),
          .b (rows[i]),
          .s (fs),
          .co(fc)
        );
      end else begin : g_cla
        cla_adder #(.W(OPW), .GRP(4)) u_add (
          .a (part[i-1][OPW:1]),
          .b (rows[i]),
          .ci(1'b0),
          .s (fs),
          .co(fc)
        );
      end
      assign part[i]       = {fc, fs};
      assign low_bits[i-1] = part[i-1][0];
    end
  endgenerate

  assign low_bits[OPW-1] = 1'b0;
  assign p = {part[OPW-1], low_bits[OPW-2:0]};
endmodule

// File: rtl/mac_row_unit.sv
module mac_row_unit #(
  parameter int unsigned OPW  = 16,
  parameter int unsigned ACCW = 40
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            in_vld,
  input  logic [OPW-1:0]  op_x,
  input  logic [OPW-1:0]  op_h,
  output logic [ACCW-1:0] acc_q
);
  localparam int unsigned PW = 2 * OPW;

  logic [PW-1:0]   prod;
  logic [ACCW-1:0] acc_next;
  logic            add_co;
  logic            take_sum;
  logic            wipe;

  row_mult #(.OPW(OPW)) u_mult (
    .a(op_x),
    .b(op_h),
    .p(prod)
  );

  cla_adder #(.W(ACCW), .GRP(4)) u_acc_add (
    .a (acc_q),
    .b (ACCW'(prod)),
    .ci(1'b0),
    .s (acc_next),
    .co(add_co)
  );

  assign wipe     = clr;
  assign take_sum = in_vld & ~clr;

  always_ff @(posedge clk) begin
    if (wipe)          acc_q <= '0;
    else if (take_sum) acc_q <= acc_next;
  end

  logic unused_co;
  assign unused_co = add_co;
endmodule

// File: rtl/mac_row_chk.sv
module mac_row_chk #(
  parameter int unsigned OPW  = 16,
  parameter int unsigned ACCW = 40
) (
  input logic            clk,
  input logic            clr,
  input logic            in_vld,
  input logic [OPW-1:0]  op_x,
  input logic [OPW-1:0]  op_h,
  input logic [2*OPW-1:0] prod,
  input logic [ACCW-1:0] acc_q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  // R1 / R6: product equals the arithmetic product
  a_r1_product: assert property (@(posedge clk) disable iff (!armed)
    in_vld |-> prod == ((2*OPW)'(op_x) * (2*OPW)'(op_h)));

  // R2 / R5 / R7: accumulate with wrap
  a_r2_accumulate: assert property (@(posedge clk) disable iff (!armed)
    (in_vld && !clr) |=> acc_q == ACCW'($past(acc_q) + ACCW'($past(prod))));

  // R3: clear zeroes the total
  a_r3_clear: assert property (@(posedge clk) disable iff (1'b0)
    clr |=> acc_q == '0);

  // R4: idle cycle holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!armed)
    (!in_vld && !clr) |=> $stable(acc_q));
endmodule

bind mac_row_unit mac_row_chk #(.OPW(OPW), .ACCW(ACCW)) u_chk (
  .clk   (clk),
  .clr   (clr),
  .in_vld(in_vld),
  .op_x  (op_x),
  .op_h  (op_h),
  .prod  (prod),
  .acc_q (acc_q)
);

// File: tb/mac_row_unit_test.sv
module mac_row_unit_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        clr = 1'b0;
  logic        in_vld = 1'b0;
  logic [15:0] op_x = '0;
  logic [15:0] op_h = '0;
  logic [39:0] acc_q;

  logic [39:0] model = '0;
  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  mac_row_unit uut (
    .clk(clk), .clr(clr), .in_vld(in_vld),
    .op_x(op_x), .op_h(op_h), .acc_q(acc_q)
  );

  task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: acc_q=%h expected=%h", req, got, exp);
    end
  endtask

  // Apply one cycle, update the model, check after the edge.
  task automatic tick(input logic c, input logic v, input logic [15:0] x,
                      input logic [15:0] h, input string req);
    clr = c; in_vld = v; op_x = x; op_h = h;
    @(posedge clk);
    #1;
    if (c)      model = '0;
    else if (v) model = model + (40'(x) * 40'(h));
    check(req, acc_q, model);
  endtask

  initial begin
    // reset state (R3)
    tick(1'b1, 1'b1, 16'h1234, 16'h5678, "R3 reset");

    // R1 / R6: walking single bits and zero, every pair
    for (int a = 0; a <= 16; a++) begin
      for (int b = 0; b <= 16; b++) begin
        logic [15:0] xv, hv;
        logic [39:0] want;
        xv = (a == 16) ? 16'h0 : (16'h1 << a);
        hv = (b == 16) ? 16'h0 : (16'h1 << b);
        want = (a == 16 || b == 16) ? 40'h0 : (40'h1 << (a + b));
        tick(1'b1, 1'b0, 16'h0, 16'h0, "R3 clear");
        tick(1'b0, 1'b1, xv, hv, "R6 single bit");
        check("R6 shift product", acc_q, want);
      end
    end

    // R1 corner values
    tick(1'b1, 1'b0, 0, 0, "R3 clear");
    tick(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, "R1 max");
    check("R1 max literal", acc_q, 40'hFFFE0001);
    tick(1'b1, 1'b0, 0, 0, "R3 clear");
    tick(1'b0, 1'b1, 16'h0000, 16'hFFFF, "R1 zero x");
    tick(1'b1, 1'b0, 0, 0, "R3 clear");
    tick(1'b0, 1'b1, 16'hFFFF, 16'h0001, "R1 unit h");
    check("R1 unit literal", acc_q, 40'h000000FFFF);

    // R2 / R7: back-to-back random valid cycles
    tick(1'b1, 1'b0, 0, 0, "R3 clear");
    for (int n = 0; n < 300; n++)
      tick(1'b0, 1'b1, 16'($urandom), 16'($urandom), "R7 back-to-back");

    // R4: gaps with busy operands
    for (int n = 0; n < 100; n++) begin
      tick(1'b0, 1'b1, 16'($urandom), 16'($urandom), "R2 add");
      tick(1'b0, 1'b0, 16'hFFFF, 16'($urandom), "R4 hold");
      tick(1'b0, 1'b0, 16'($urandom), 16'hFFFF, "R4 hold");
    end

    // R3: clear beats valid
    tick(1'b0, 1'b1, 16'hABCD, 16'h1357, "R2 add");
    tick(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, "R3 clear priority");
    check("R3 priority zero", acc_q, 40'h0);

    // R5: wrap modulo 2^40
    for (int n = 0; n < 260; n++)
      tick(1'b0, 1'b1, 16'hFFFF, 16'hFFFF, "R5 long run");
    begin
      logic [63:0] full;
      full = 64'd260 * 64'hFFFE0001;
      check("R5 wrap value", acc_q, full[39:0]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: acc_q=%h expected=completion", acc_q);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule